// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block is a register-level model of a programmable interval timer. It has three independent 16-bit down-counters behind a byte-wide port with four addresses. Addresses 0, 1 and 2 reach the data port of counters 0, 1 and 2. Address 3 takes control words. Every counter advances on a shared count-enable strobe (`cnt_tick`). Each counter can count in plain binary or in four-digit packed BCD.

Software programs a counter in three steps. It writes a control word that picks the byte-access pattern, the counting mode and the number base. It then writes the reload value one or two bytes at a time. It reads the count back either live or through a frozen latch. A read-back command can latch counts and status bytes on several counters at once. For each counter the block drives two outputs: a one-cycle terminal-count pulse and the reload value now in force. It also drives an update-pending flag that stays set from the control write until the last reload byte arrives.

Top module: `pit3_core`

## Requirements
- R1: After reset, the control fields are 0x36, 0x74 and 0xB6 for counters 0, 1 and 2, the reload values are 0xFFFF, 0x0012 and 0x0001, no update is pending, and the counts equal the reload values.
- R2: A control word goes to address 3. Bits 7:6 pick the counter, where 3 means read-back. Bits 5:4 set the access pattern: 0 latch, 1 low only, 2 high only, 3 low then high. Bits 3:1 set the mode and bit 0 selects BCD. A control word with access pattern 1 to 3 stores the control fields, zeroes the reload value and the count, sets update-pending, and clears that counter's toggles, latch and pending status.
- R3: Data writes follow the access pattern. Low only replaces bits 7:0 and high only replaces bits 15:8, and each completes programming at once. With low then high, a write toggle sends the first byte low and the second byte high, and programming completes on the second byte. When programming completes, the count loads the new reload value and update-pending clears.
- R4: While update-pending is set, the count holds still and produces no terminal-count pulse.
- R5: Data reads follow the access pattern through their own toggle, separate from the write toggle. Low only returns bits 7:0, high only returns bits 15:8, and low then high alternates between them. A read returns the latched value if one is held and the live count otherwise. The read is registered: `bus_rdata` updates on the clock edge that samples `bus_rd`.
- R6: A latch command freezes the current count. Later latch commands on that counter are ignored until the held value has been fully read out.
- R7: A read-back command has bits 7:6 = 3. Bits 1, 2 and 3 select counters 0, 1 and 2. Bit 5 low latches the count and bit 4 low requests status.
- R8: The status byte is {0, update-pending, control bits 5:0}. A pending status is returned by the next read of that counter in place of count data, and it is consumed by that read.
- R9: Modes whose bit 1 is set (2, 3, 6, 7) are periodic. On a tick at count 1 the count reloads the programmed value, and a one-cycle terminal-count pulse follows on the next edge.
- R10: Modes 0, 1, 4 and 5 pass from 1 to 0 with a terminal-count pulse. They then wrap from 0 to 0xFFFF in binary or 0x9999 in BCD.
- R11: In BCD the count decrements as four decimal digits with borrow across nibbles. A reload of 0 gives a period of 10000 ticks in BCD and 65536 in binary.
- R12: Reads of address 3 return 0xFF. `reload_o` changes only after a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count-enable strobe shared by all counters |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 2 | 0..2 counter data, 3 control |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| tc_pulse | output | 3 | Per-counter terminal-count pulse |
| reload_o | output | 48 | Reload values, counter i in bits 16i+15:16i |
| upd_pend | output | 3 | Per-counter update-pending flag |

## Verification
A wrong toggle, latch or status flag inside a counter shows up on `bus_rdata` at the next read of that counter. The symptom is a swapped byte, a live count where a frozen one was expected, or count data where a status byte should be. A bad decrement or reload shows up one tick later in the spacing of `tc_pulse`. The same fault also appears in any latched count read afterwards. The bench compares the read bytes with a counting model written from the requirements and counts terminal pulses over whole periods, including the 10000-tick BCD period.

// File: rtl/pit3_pkg.sv
package pit3_pkg;
  localparam int NCH   = 3;
  localparam int BW    = 8;
  localparam int CW    = 16;
  localparam int DIGS  = CW / 4;
  localparam int AW    = 2;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  function automatic logic [7:0] rst_ctl(input int i);
    case (i)
      0:       return 8'h36;
      1:       return 8'h74;
      default: return 8'hB6;
    endcase
  endfunction

  function automatic logic [CW-1:0] rst_reload(input int i);
    case (i)
      0:       return 16'hFFFF;
      1:       return 16'h0012;
      default: return 16'h0001;
    endcase
  endfunction
endpackage

// File: rtl/pit3_down.sv
module pit3_down
  import pit3_pkg::*;
(
  input  logic [CW-1:0] val,
  input  logic          bcd,
  output logic [CW-1:0] nxt
);
  logic [CW-1:0] bcd_res;

  always_comb begin
    logic borrow;
    borrow  = 1'b1;
    bcd_res = val;
    for (int d = 0; d < DIGS; d++) begin
      if (borrow) begin
        if (val[4*d +: 4] == 4'd0) begin
          bcd_res[4*d +: 4] = 4'd9;
        end else begin
          bcd_res[4*d +: 4] = val[4*d +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
  end

  assign nxt = bcd ? bcd_res : (val - 1'b1);
endmodule

// File: rtl/pit3_dec.sv
module pit3_dec
  import pit3_pkg::*;
(
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:1]    cmd,
  output logic [NCH-1:0] ctl_wr,
  output logic [NCH-1:0] latch_req,
  output logic [NCH-1:0] stat_req,
  output logic [NCH-1:0] data_wr,
  output logic [NCH-1:0] data_rd
);
  logic ctl_sel, rb;
  assign ctl_sel = bus_wr && (bus_addr == AW'(NCH));
  assign rb      = (cmd[7:6] == 2'd3);

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    logic hit;
    assign hit          = (cmd[7:6] == 2'(g));
    assign ctl_wr[g]    = ctl_sel && hit && (cmd[5:4] != ACC_LATCH);
    assign latch_req[g] = ctl_sel && ((hit && cmd[5:4] == ACC_LATCH) ||
                                      (rb && !cmd[5] && cmd[1+g]));
    assign stat_req[g]  = ctl_sel && rb && !cmd[4] && cmd[1+g];
    assign data_wr[g]   = bus_wr && (bus_addr == AW'(g));
    assign data_rd[g]   = bus_rd && (bus_addr == AW'(g));
  end
endmodule

// File: rtl/pit3_chan.sv
module pit3_chan
  import pit3_pkg::*;
#(
  parameter logic [7:0]    RST_CTL = 8'h36,
  parameter logic [CW-1:0] RST_RLD = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctl_wr,
  input  logic [5:0]    ctl_val,
  input  logic          latch_req,
  input  logic          stat_req,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rd_byte,
  output logic          tc_o,
  output logic [CW-1:0] reload_o,
  output logic          pend_o
);
  logic [5:0]    ctl;
  logic [CW-1:0] rld, cnt, lval, src, wr_next, dec;
  logic          pend, wtog, rtog, latched, spend;
  acc_e          acc;
  logic          periodic, bcd, wr_done;

  assign acc      = acc_e'(ctl[5:4]);
  assign periodic = ctl[2];
  assign bcd      = ctl[0];
  assign src      = latched ? lval : cnt;

  pit3_down u_down (.val(cnt), .bcd(bcd), .nxt(dec));

  always_comb begin
    wr_next = rld;
    wr_done = 1'b0;
    case (acc)
      ACC_LO:   begin wr_next = {rld[15:8], wdata}; wr_done = 1'b1; end
      ACC_HI:   begin wr_next = {wdata, rld[7:0]};  wr_done = 1'b1; end
      ACC_LOHI: begin
        wr_next = wtog ? {wdata, rld[7:0]} : {rld[15:8], wdata};
        wr_done = wtog;
      end
      default:  ;
    endcase
  end

  always_comb begin
    if (spend) begin
      rd_byte = {1'b0, pend, ctl};
    end else begin
      case (acc)
        ACC_LO:   rd_byte = src[7:0];
        ACC_HI:   rd_byte = src[15:8];
        ACC_LOHI: rd_byte = rtog ? src[15:8] : src[7:0];
        default:  rd_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= RST_CTL[5:0];
      rld     <= RST_RLD;
      cnt     <= RST_RLD;
      lval    <= '0;
      pend    <= 1'b0;
      wtog    <= 1'b0;
      rtog    <= 1'b0;
      latched <= 1'b0;
      spend   <= 1'b0;
      tc_o    <= 1'b0;
    end else begin
      tc_o <= 1'b0;
      if (ctl_wr) begin
        ctl     <= ctl_val;
        rld     <= '0;
        cnt     <= '0;
        pend    <= 1'b1;
        wtog    <= 1'b0;
        rtog    <= 1'b0;
        latched <= 1'b0;
        spend   <= 1'b0;
      end else begin
        if (data_wr && acc != ACC_LATCH) begin
          rld  <= wr_next;
          pend <= !wr_done;
          if (acc == ACC_LOHI) wtog <= !wtog;
          if (wr_done) cnt <= wr_next;
        end else if (tick && !pend) begin
          if (cnt == CW'(1)) begin
            cnt  <= periodic ? rld : '0;
            tc_o <= 1'b1;
          end else begin
            cnt <= dec;
          end
        end
        if (data_rd) begin
          if (spend) begin
            spend <= 1'b0;
          end else begin
            case (acc)
              ACC_LO, ACC_HI: latched <= 1'b0;
              ACC_LOHI: begin
                rtog <= !rtog;
                if (rtog) latched <= 1'b0;
              end
              default: ;
            endcase
          end
        end
        if (latch_req && !latched) begin
          latched <= 1'b1;
          lval    <= cnt;
        end
        if (stat_req) spend <= 1'b1;
      end
    end
  end

  assign reload_o = rld;
  assign pend_o   = pend;
endmodule

// File: rtl/pit3_core.sv
module pit3_core
  import pit3_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [2:0]        tc_pulse,
  output logic [47:0]       reload_o,
  output logic [2:0]        upd_pend
);
  logic [NCH-1:0] ctl_wr, latch_req, stat_req, data_wr, data_rd;
  logic [BW-1:0]  rd_byte [NCH];

  pit3_dec u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .cmd(bus_wdata[7:1]),
    .ctl_wr(ctl_wr), .latch_req(latch_req), .stat_req(stat_req),
    .data_wr(data_wr), .data_rd(data_rd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pit3_chan #(.RST_CTL(rst_ctl(g)), .RST_RLD(rst_reload(g))) u_ch (
      .clk(clk), .rst(rst), .tick(cnt_tick),
      .ctl_wr(ctl_wr[g]), .ctl_val(bus_wdata[5:0]),
      .latch_req(latch_req[g]), .stat_req(stat_req[g]),
      .data_wr(data_wr[g]), .data_rd(data_rd[g]), .wdata(bus_wdata),
      .rd_byte(rd_byte[g]), .tc_o(tc_pulse[g]),
      .reload_o(reload_o[CW*g +: CW]), .pend_o(upd_pend[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        2'd0:    bus_rdata <= rd_byte[0];
        2'd1:    bus_rdata <= rd_byte[1];
        2'd2:    bus_rdata <= rd_byte[2];
        default: bus_rdata <= 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/pit3_core_chk.sv
module pit3_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        cnt_tick,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [2:0]  tc_pulse,
  input logic [47:0] reload_o,
  input logic [2:0]  upd_pend
);
  for (genvar g = 0; g < 3; g++) begin : g_chk
    // R9
    tc_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
      tc_pulse[g] |-> $past(cnt_tick));
    // R4
    pend_no_tc_chk: assert property (@(posedge clk) disable iff (rst)
      upd_pend[g] |=> !tc_pulse[g]);
    // R2
    pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(upd_pend[g]) |-> $past(bus_wr));
    // R3
    pend_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(upd_pend[g]) |-> $past(bus_wr && bus_addr == 2'(g)));
  end
  // R12
  reload_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(reload_o));
endmodule

bind pit3_core pit3_core_chk u_chk (
  .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .tc_pulse(tc_pulse), .reload_o(reload_o), .upd_pend(upd_pend)
);

// File: tb/pit3_core_tb_top.sv
module pit3_core_tb_top;
  logic        clk = 1'b0;
  logic        rst, cnt_tick, bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [2:0]  tc_pulse, upd_pend;
  logic [47:0] reload_o;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = !clk;

  pit3_core dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n, input int ch, output int ntc, output logic last);
    ntc = 0; last = 1'b0;
    cnt_tick = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      last = tc_pulse[ch];
      if (last) ntc++;
    end
    cnt_tick = 1'b0;
  endtask

  function automatic int exp_cnt(input int r, input int n);
    int c = r;
    for (int k = 0; k < n; k++) c = (c == 1) ? r : c - 1;
    return c;
  endfunction

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] b, h;
    int n, r;
    logic last;
    void'($urandom(32'h5EED));
    rst = 1'b1; cnt_tick = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 reload", int'(reload_o), int'(48'h0001_0012_FFFF));
    chk("R1 pend", int'(upd_pend), 0);
    wr(3, 8'hEE);                       // R7 status for all three
    rd(0, b); chk("R1 R8 status0", b, 8'h36);
    rd(1, b); chk("R1 R8 status1", b, 8'h34);
    rd(2, b); chk("R1 R8 status2", b, 8'h36);
    rd(1, b); rd(1, h); chk("R1 count1", {h, b}, 16'h0012);
    rd(3, b); chk("R12 ctl read", b, 8'hFF);

    // R2 control word, R4 frozen while pending
    wr(3, 8'h34);
    chk("R2 pend", upd_pend[0], 1);
    chk("R2 reload cleared", reload_o[15:0], 0);
    wr(3, 8'hE2); rd(0, b); chk("R8 pend status", b, 8'h74);
    ticks(5, 0, n, last); chk("R4 no tc pending", n, 0);
    rd(0, b); rd(0, h); chk("R4 frozen count", {h, b}, 0);
    // R3 low then high
    wr(0, 8'h05); chk("R3 mid pend", upd_pend[0], 1);
    chk("R3 low byte", reload_o[15:0], 5);
    wr(0, 8'h00); chk("R3 done", upd_pend[0], 0);
    // R9 periodic
    ticks(20, 0, n, last); chk("R9 tc count", n, 4); chk("R9 last tc", last, 1);
    ticks(2, 0, n, last);
    wr(3, 8'h00);                       // latch 3
    ticks(3, 0, n, last);
    wr(3, 8'h00);                       // R6 ignored
    rd(0, b); rd(0, h); chk("R6 held", {h, b}, 3);
    wr(3, 8'h00);
    rd(0, b); rd(0, h); chk("R6 relatch", {h, b}, 5);

    // R11 BCD, R10 wrap
    wr(3, 8'h71); wr(1, 8'h00); wr(1, 8'h10);
    ticks(1, 1, n, last);
    wr(3, 8'h40); rd(1, b); rd(1, h); chk("R11 bcd borrow", {h, b}, 16'h0999);
    wr(1, 8'h02); wr(1, 8'h00);
    ticks(2, 1, n, last); chk("R10 tc at 1->0", last, 1);
    ticks(1, 1, n, last);
    wr(3, 8'h40); rd(1, b); rd(1, h); chk("R10 bcd wrap", {h, b}, 16'h9999);

    // R3 single byte modes, R5 read patterns
    wr(3, 8'h96); wr(2, 8'h07);
    chk("R3 low only", reload_o[47:32], 16'h0007); chk("R3 lo done", upd_pend[2], 0);
    rd(2, b); chk("R5 low only read", b, 8'h07);
    wr(3, 8'hA6); wr(2, 8'h02);
    chk("R3 high only", reload_o[47:32], 16'h0200);
    rd(2, b); rd(2, h); chk("R5 high only twice", {h, b}, 16'h0202);
    // R7 R8 combined read-back
    wr(3, 8'hC8);
    rd(2, b); chk("R8 status first", b, 8'h26);
    rd(2, b); chk("R7 latched count", b, 8'h02);

    // R11 zero reload = 10000 in BCD
    wr(3, 8'hB5); wr(2, 8'h00); wr(2, 8'h00);
    ticks(10000, 2, n, last);
    chk("R11 zero period", n, 1); chk("R11 zero period end", last, 1);

    // random periodic binary, R9 R5
    wr(3, 8'h34);
    for (int it = 0; it < 20; it++) begin
      r = 2 + int'($urandom_range(298));
      n = int'($urandom_range(700));
      wr(0, r[7:0]); wr(0, r[15:8]);
      ticks(n, 0, h, last);
      wr(3, 8'h00);
      rd(0, b); rd(0, h);
      chk("R9 random count", {h, b}, exp_cnt(r, n));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule